// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel that watches a free-running 16-bit timer count and drives a single output pin. Two timer counts and their period-match strobes come in, and a select input picks which of the two the channel follows. Two compare values, a primary and a secondary, decide where the output changes.

A 3-bit mode, loaded through a small write port, picks the behaviour. The modes are: off, drive high on a match, drive low on a match, toggle on a match, one dual-compare pulse, repeated dual-compare pulses, pulse-width modulation (PWM), and PWM with a fault shutdown. Each compare or PWM event raises a one-cycle interrupt pulse. In the fault-protected PWM mode, an active-low fault input releases the pin by dropping the output enable. It also sets a fault flag, which stays set until the mode is written again.

Internally a controller moves through seven named states:
- `S_OFF`: idle.
- `S_SINGLE`: armed for single matches.
- `S_ARM`: waiting for the first edge of a dual-compare pulse.
- `S_FALL`: waiting for the second edge.
- `S_DONE`: one-shot pulse finished.
- `S_PWM`: running PWM.
- `S_FAULT`: shut down by a fault.

A mode write moves the controller to the entry state for the new mode: `S_OFF`, `S_SINGLE`, `S_ARM` or `S_PWM`. The other transitions are:
- `S_ARM` goes to `S_FALL` on a primary match.
- `S_FALL` goes to `S_DONE` on a secondary match in one-shot mode, and back to `S_ARM` in repeat mode.
- `S_PWM` goes to `S_FAULT` on a fault in the fault-protected mode.

All outputs are registered. An input sampled at one clock edge shows at the outputs right after that edge.

Top module: `oc_channel`

## Requirements
- R1: While `rst_n` is low and right after reset, `oc_pin`=0, `oc_oe`=1, `irq_pulse`=0 and `fault_flag`=0, and the mode is off.
- R2: With `tsel`=0 the channel compares `tmr_a` and uses `prd_a`. With `tsel`=1 it compares `tmr_b` and uses `prd_b`. The unselected timer has no effect on the pin.
- R3: In mode 001 a primary match (`count == cmp_pri`) drives the pin high on the next edge. Mode 010 drives it low and mode 011 inverts it. Every such match gives `irq_pulse`=1 for that one cycle.
- R4: In mode 100 a primary match drives the pin high. The next secondary match (`count == cmp_sec`) drives it low with an interrupt pulse. After that the pin stays low and further matches have no effect.
- R5: Mode 101 behaves like mode 100 but re-arms after each falling edge, so the pulses repeat.
- R6: In modes 110 and 111 a period strobe drives the pin high, loads the duty value from `cmp_sec` and pulses `irq_pulse`. If there is no period strobe, a count equal to the duty value drives the pin low. The period strobe wins when both occur.
- R7: The duty value changes only on a period strobe in PWM. A change of `cmp_sec` between strobes does not move the falling edge.
- R8: In mode 111 a low on `flt_n` gives `oc_oe`=0, `oc_pin`=0 and `fault_flag`=1. These hold until the next mode write. Mode 110 ignores `flt_n`.
- R9: A write (`cfg_we`=1) loads `cfg_mode` and clears the pin, the fault flag and any pulse in progress. Mode 000 keeps the pin low.
- R10: `irq_pulse` lasts one cycle per event. In dual-compare modes it fires only on the second edge, not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_a | input | 16 | First timer count |
| tmr_b | input | 16 | Second timer count |
| prd_a | input | 1 | Period-match strobe of the first timer |
| prd_b | input | 1 | Period-match strobe of the second timer |
| tsel | input | 1 | Timer select: 0 first, 1 second |
| cmp_pri | input | 16 | Primary compare value |
| cmp_sec | input | 16 | Secondary compare value, also the PWM duty source |
| flt_n | input | 1 | Active-low fault input |
| cfg_we | input | 1 | Mode write strobe |
| cfg_mode | input | 3 | Mode value to write |
| oc_pin | output | 1 | Output pin level |
| oc_oe | output | 1 | Output enable; low means the pin is released |
| irq_pulse | output | 1 | One-cycle interrupt event |
| fault_flag | output | 1 | Sticky fault status |

## Verification
Any wrong controller state shows on `oc_pin`, `oc_oe` or `irq_pulse` at the next match, period or fault event. For example, a one-shot that re-arms in error gives a second rising edge, and a state that skips `S_FALL` gives an interrupt without a falling edge. A wrong duty register shows as a falling edge at the wrong count within one PWM period. Because every output is registered, a fault appears one clock after the event that exposes it. The bench compares the ports against its model on every clock, so divergence is reported in that cycle.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int TMR_W  = 16;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_OFF    = 3'd0,
        MD_SET    = 3'd1,
        MD_CLR    = 3'd2,
        MD_TGL    = 3'd3,
        MD_PULSE1 = 3'd4,
        MD_PULSEN = 3'd5,
        MD_PWM    = 3'd6,
        MD_PWMF   = 3'd7
    } oc_mode_e;

    typedef enum logic [2:0] {
        S_OFF, S_SINGLE, S_ARM, S_FALL, S_DONE, S_PWM, S_FAULT
    } oc_state_e;

    function automatic oc_state_e entry_state(oc_mode_e m);
        case (m)
            MD_OFF:                 return S_OFF;
            MD_SET, MD_CLR, MD_TGL: return S_SINGLE;
            MD_PULSE1, MD_PULSEN:   return S_ARM;
            default:                return S_PWM;
        endcase
    endfunction
endpackage

// File: rtl/oc_tmr_sel.sv
module oc_tmr_sel #(
    parameter int W = 16
) (
    input  logic [W-1:0] tmr_a,
    input  logic [W-1:0] tmr_b,
    input  logic         prd_a,
    input  logic         prd_b,
    input  logic         tsel,
    input  logic [W-1:0] cmp_pri,
    input  logic [W-1:0] cmp_sec,
    input  logic [W-1:0] duty,
    output logic         hit_pri,
    output logic         hit_sec,
    output logic         hit_duty,
    output logic         prd
);
    logic [W-1:0] cnt;

    always_comb begin
        cnt      = tsel ? tmr_b : tmr_a;
        prd      = tsel ? prd_b : prd_a;
        hit_pri  = (cnt == cmp_pri);
        hit_sec  = (cnt == cmp_sec);
        hit_duty = (cnt == duty);
    end
endmodule

// File: rtl/oc_duty_reg.sv
module oc_duty_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] src,
    output logic [W-1:0] duty
);
    always_ff @(posedge clk) begin
        if (!rst_n)  duty <= '0;
        else if (ld) duty <= src;
    end

    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(duty)); // R7
endmodule

// File: rtl/oc_ctrl_fsm.sv
module oc_ctrl_fsm
    import oc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_we,
    input  oc_mode_e new_mode,
    input  oc_mode_e mode,
    input  logic     hit_pri,
    input  logic     hit_sec,
    input  logic     hit_duty,
    input  logic     prd,
    input  logic     flt_n,
    output logic     pin,
    output logic     oe,
    output logic     irq,
    output logic     fault,
    output logic     duty_ld
);
    oc_state_e state, state_nx;
    logic      pin_nx, irq_nx, fault_nx;

    // next-state and next-output decode
    always_comb begin
        state_nx = state;
        pin_nx   = pin;
        irq_nx   = 1'b0;
        fault_nx = fault;
        duty_ld  = 1'b0;
        if (cfg_we) begin
            state_nx = entry_state(new_mode);
            pin_nx   = 1'b0;
            fault_nx = 1'b0;
        end else begin
            unique case (state)
                S_OFF: pin_nx = 1'b0;
                S_SINGLE: if (hit_pri) begin
                    irq_nx = 1'b1;
                    unique case (mode)
                        MD_SET:  pin_nx = 1'b1;
                        MD_CLR:  pin_nx = 1'b0;
                        default: pin_nx = ~pin;
                    endcase
                end
                S_ARM: if (hit_pri) begin
                    pin_nx   = 1'b1;
                    state_nx = S_FALL;
                end
                S_FALL: if (hit_sec) begin
                    pin_nx   = 1'b0;
                    irq_nx   = 1'b1;
                    state_nx = (mode == MD_PULSE1) ? S_DONE : S_ARM;
                end
                S_DONE: pin_nx = 1'b0;
                S_PWM: begin
                    if (mode == MD_PWMF && !flt_n) begin
                        pin_nx   = 1'b0;
                        fault_nx = 1'b1;
                        state_nx = S_FAULT;
                    end else if (prd) begin
                        pin_nx  = 1'b1;
                        irq_nx  = 1'b1;
                        duty_ld = 1'b1;
                    end else if (hit_duty) begin
                        pin_nx = 1'b0;
                    end
                end
                S_FAULT: pin_nx = 1'b0;
                default: state_nx = S_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_OFF;
        else        state <= state_nx;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin   <= 1'b0;
            irq   <= 1'b0;
            fault <= 1'b0;
        end else begin
            pin   <= pin_nx;
            irq   <= irq_nx;
            fault <= fault_nx;
        end
    end

    assign oe = (state != S_FAULT);

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!pin && !fault)); // R9
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !cfg_we) |=> fault); // R8
    AST_OE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (fault && !pin)); // R8
    AST_DONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) |-> !pin); // R4
    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_TGL && irq) |-> (pin != $past(pin))); // R3
endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int TW = TMR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     tmr_a,
    input  logic [TW-1:0]     tmr_b,
    input  logic              prd_a,
    input  logic              prd_b,
    input  logic              tsel,
    input  logic [TW-1:0]     cmp_pri,
    input  logic [TW-1:0]     cmp_sec,
    input  logic              flt_n,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_mode,
    output logic              oc_pin,
    output logic              oc_oe,
    output logic              irq_pulse,
    output logic              fault_flag
);
    oc_mode_e      mode_q;
    oc_mode_e      mode_in;
    logic [TW-1:0] duty;
    logic          hit_pri, hit_sec, hit_duty, prd, duty_ld;

    assign mode_in = oc_mode_e'(cfg_mode);

    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= MD_OFF;
        else if (cfg_we) mode_q <= mode_in;
    end

    oc_tmr_sel #(.W(TW)) u_sel (
        .tmr_a(tmr_a), .tmr_b(tmr_b), .prd_a(prd_a), .prd_b(prd_b),
        .tsel(tsel), .cmp_pri(cmp_pri), .cmp_sec(cmp_sec), .duty(duty),
        .hit_pri(hit_pri), .hit_sec(hit_sec), .hit_duty(hit_duty), .prd(prd)
    );

    oc_duty_reg #(.W(TW)) u_duty (
        .clk(clk), .rst_n(rst_n), .ld(duty_ld), .src(cmp_sec), .duty(duty)
    );

    oc_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .new_mode(mode_in),
        .mode(mode_q), .hit_pri(hit_pri), .hit_sec(hit_sec),
        .hit_duty(hit_duty), .prd(prd), .flt_n(flt_n),
        .pin(oc_pin), .oe(oc_oe), .irq(irq_pulse), .fault(fault_flag),
        .duty_ld(duty_ld)
    );

    AST_PWM_EVENT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MD_PWM || mode_q == MD_PWMF) && irq_pulse) |-> oc_pin); // R6
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_OFF) |-> (!oc_pin && !irq_pulse)); // R9
endmodule

// File: tb/tb_oc_channel.sv
module tb_oc_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmr_a = '0, tmr_b = '0, cmp_pri = '0, cmp_sec = '0;
    logic        prd_a = 1'b0, prd_b = 1'b0, tsel = 1'b0, flt_n = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_mode = '0;
    logic        oc_pin, oc_oe, irq_pulse, fault_flag;

    int checks = 0, errors = 0;
    string tag = "R1";

    // reference model (0 off,1 single,2 arm,3 fall,4 done,5 pwm,6 fault)
    int          mst = 0;
    logic [2:0]  mmode = 3'd0;
    logic [15:0] mduty = '0;
    logic        mpin = 1'b0, mirq = 1'b0, mflt = 1'b0;

    always #10 clk = ~clk;

    oc_channel dut (
        .clk(clk), .rst_n(rst_n), .tmr_a(tmr_a), .tmr_b(tmr_b),
        .prd_a(prd_a), .prd_b(prd_b), .tsel(tsel), .cmp_pri(cmp_pri),
        .cmp_sec(cmp_sec), .flt_n(flt_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .oc_pin(oc_pin), .oc_oe(oc_oe), .irq_pulse(irq_pulse),
        .fault_flag(fault_flag)
    );

    function automatic int entry(logic [2:0] m);
        if (m == 3'd0) return 0;
        if (m <= 3'd3) return 1;
        if (m <= 3'd5) return 2;
        return 5;
    endfunction

    task automatic model_step();
        logic [15:0] c;
        logic        p;
        c = tsel ? tmr_b : tmr_a;
        p = tsel ? prd_b : prd_a;
        mirq = 1'b0;
        if (!rst_n) begin
            mst = 0; mmode = 3'd0; mduty = '0; mpin = 1'b0; mflt = 1'b0;
        end else if (cfg_we) begin
            mmode = cfg_mode; mst = entry(cfg_mode); mpin = 1'b0; mflt = 1'b0;
        end else begin
            case (mst)
                1: if (c == cmp_pri) begin
                    mirq = 1'b1;
                    mpin = (mmode == 3'd1) ? 1'b1 : (mmode == 3'd2) ? 1'b0 : ~mpin;
                end
                2: if (c == cmp_pri) begin mpin = 1'b1; mst = 3; end
                3: if (c == cmp_sec) begin
                    mpin = 1'b0; mirq = 1'b1; mst = (mmode == 3'd4) ? 4 : 2;
                end
                5: begin
                    if (mmode == 3'd7 && !flt_n) begin mpin = 1'b0; mflt = 1'b1; mst = 6; end
                    else if (p) begin mpin = 1'b1; mirq = 1'b1; mduty = cmp_sec; end
                    else if (c == mduty) mpin = 1'b0;
                end
                default: mpin = 1'b0;
            endcase
        end
    endtask

    task automatic check(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        check("oc_pin", oc_pin, mpin);
        check("oc_oe", oc_oe, mst != 6);
        check("irq_pulse", irq_pulse, mirq);
        check("fault_flag", fault_flag, mflt);
        cfg_we = 1'b0; prd_a = 1'b0; prd_b = 1'b0;
    endtask

    task automatic wr(logic [2:0] m);
        cfg_we = 1'b1; cfg_mode = m; tick();
    endtask

    task automatic cnt(logic [15:0] v);
        if (tsel) tmr_b = v; else tmr_a = v;
        tick();
    endtask

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        tag = "R1";
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check("reset pin", oc_pin, 1'b0);

        // R3 set / clear / toggle
        tag = "R3";
        cmp_pri = 16'd5; wr(3'd1);
        cnt(16'd4); cnt(16'd5);
        check("set match", oc_pin, 1'b1);
        wr(3'd3); cnt(16'd5); cnt(16'd5);
        wr(3'd2); cnt(16'd5);
        check("clear match", oc_pin, 1'b0);

        // R2 timer selection: unselected timer matches are ignored
        tag = "R2";
        wr(3'd1); tsel = 1'b1; tmr_b = 16'd1; tmr_a = 16'd5; tick();
        check("unselected timer", oc_pin, 1'b0);
        cnt(16'd5);
        check("selected timer", oc_pin, 1'b1);
        tsel = 1'b0;

        // R4 one-shot pulse, then further matches ignored
        tag = "R4";
        cmp_pri = 16'd2; cmp_sec = 16'd6; wr(3'd4);
        for (int i = 0; i < 20; i++) cnt(16'(i % 8));
        check("one-shot stays low", oc_pin, 1'b0);

        // R5 / R10 repeated pulses and interrupt only on second edge
        tag = "R5";
        wr(3'd5);
        for (int i = 0; i < 24; i++) cnt(16'(i % 8));
        tag = "R10";
        cnt(16'd2);
        check("no irq on first edge", irq_pulse, 1'b0);

        // R6 / R7 PWM with duty reload only at period
        tag = "R6";
        cmp_sec = 16'd3; wr(3'd6);
        for (int p = 0; p < 3; p++)
            for (int i = 0; i < 8; i++) begin
                prd_a = (i == 0); cnt(16'(i));
            end
        tag = "R7";
        cmp_sec = 16'd6;
        cnt(16'd1); cnt(16'd2); cnt(16'd3);
        check("old duty still used", oc_pin, 1'b0);

        // R8 fault shutdown; mode 110 ignores the fault input
        tag = "R8";
        flt_n = 1'b0; cnt(16'd4);
        check("mode 110 ignores fault", oc_oe, 1'b1);
        wr(3'd7); cnt(16'd0); cnt(16'd1);
        check("fault releases pin", oc_oe, 1'b0);
        flt_n = 1'b1; prd_a = 1'b1; cnt(16'd0);
        check("fault sticky", fault_flag, 1'b1);
        tag = "R9";
        wr(3'd0);
        check("write clears fault", fault_flag, 1'b0);

        // random mix
        tag = "R10";
        for (int i = 0; i < 3000; i++) begin
            tmr_a = 16'($urandom_range(0, 7));
            tmr_b = 16'($urandom_range(0, 7));
            prd_a = ($urandom_range(0, 7) == 0);
            prd_b = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 15) == 0) cmp_pri = 16'($urandom_range(0, 7));
            if ($urandom_range(0, 15) == 0) cmp_sec = 16'($urandom_range(0, 7));
            if ($urandom_range(0, 63) == 0) tsel = ~tsel;
            flt_n = ($urandom_range(0, 31) != 0);
            if ($urandom_range(0, 40) == 0) begin
                cfg_we = 1'b1; cfg_mode = 3'($urandom_range(0, 7));
            end
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule